// File: doc/BRIEF.md
# Multi-Mode Timer/Counter

This block is a general-purpose timer/counter. One counter sits behind a power-of-two prescaler. It works with two compare registers, named Rise and Fall, to provide four functions:

- a repeating or single-shot interval timer whose period is the Fall value;
- a pulse-width-modulated output that goes high at Rise and low at Fall;
- an input capture that records the count at each edge of an external signal;
- an event counter that advances on rising edges of an external clock/gate pin.

Software sets the unit up through a small write port and reads back the counter and the two compare registers. Both external pins pass through a synchronizer before the counter logic sees them. Each compare register has its own interrupt line, and each line gives a one-cycle pulse.

When the gate function is selected, the clock/gate pin freezes the count for as long as it is high. A separate output-enable bit decides whether the PWM pin is driven. Software starts the unit by writing the run register. A start clears both the counter and the prescaler, so every run begins from a known phase.

Top module: `modal_timer`

## Requirements
- R1: After reset the counter, both compare registers, both interrupt lines, the PWM output and the output enable are all zero.
- R2: The write port takes these addresses. Address 0 is control: bits 1:0 select the mode (0 interval timer, 1 PWM, 2 capture, 3 edge count), bit 2 selects single-shot, bit 3 enables the gate, bit 4 enables the output, bit 5 enables the Rise interrupt and bit 6 enables the Fall interrupt. Address 1 holds the prescale exponent e, address 2 Rise and address 3 Fall. A write to address 4 with bit 0 set clears the counter and prescaler and starts the run. In timer, PWM and capture modes the count then advances once every 2^e clocks, with the first increment 2^e clocks after the start edge.
- R3: In repeating timer mode the count wraps to zero when it would reach Fall. The Fall interrupt then recurs every Fall·2^e clocks.
- R4: In single-shot mode the count stops and holds at Fall after the Fall match, and only one Fall interrupt is raised.
- R5: With the gate enabled, a high level on the clock/gate pin freezes the count, and counting resumes once the pin returns low. With the gate disabled, the pin has no effect on timer counting.
- R6: In edge-count mode the counter advances by one for each rising edge on the clock/gate pin and ignores prescaler ticks.
- R7: In PWM mode the output goes high in the cycle after the count reaches Rise and goes low after it reaches Fall. The output has period Fall·2^e and is high for (Fall−Rise)·2^e clocks.
- R8: The output-enable bit appears on the output-enable pin. While the bit is clear, the PWM output stays low.
- R9: In capture mode, when the capture input rises, Rise takes the current count and a Rise interrupt is raised. When the input falls, Fall takes the count and a Fall interrupt is raised. The difference between the two equals the high or low time in counter ticks.
- R10: Each interrupt is a pulse one clock wide and is raised only when its enable bit is set.
- R11: A write to address 4 with bit 0 clear stops the count, and the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| gate_in | input | 1 | External clock/gate pin |
| cap_in | input | 1 | External capture pin |
| pwm_out | output | 1 | Timer output pin |
| pwm_oe | output | 1 | Drive enable for the timer output pin |
| irq_rise | output | 1 | Rise match or rising-capture interrupt pulse |
| irq_fall | output | 1 | Fall match or falling-capture interrupt pulse |
| count_o | output | CNT_W | Current count readback |
| rise_o | output | CNT_W | Rise register readback |
| fall_o | output | CNT_W | Fall register readback |

## Verification
The interval timer is run at two prescale exponents and two Fall values. Each gap between Fall interrupts is compared with its own expected entry, which separates a wrong prescale step from a wrong wrap point. PWM is measured with high-cycle counts over whole periods at two exponents, plus the exact cycles of the first rise and fall, so a shifted duty cycle cannot be mistaken for a shifted phase. Capture is driven with a 7-cycle high pulse followed by an 11-cycle low gap, which separates swapped edge latching from a latency mismatch between the two edges. The gate pin is exercised both with the gate enabled and with it disabled, and edge-count mode is run with a slow prescale so that counting ticks instead of edges would show up.

// File: rtl/modal_timer_pkg.sv
package modal_timer_pkg;

   typedef enum logic [1:0] {
      MODE_TIMER   = 2'd0,
      MODE_PWM     = 2'd1,
      MODE_CAPTURE = 2'd2,
      MODE_COUNT   = 2'd3
   } tmode_e;

   // control word, LSB first: mode[1:0], single[2], gate_en[3], out_en[4], rise_ie[5], fall_ie[6]
   typedef struct packed {
      logic   fall_ie;
      logic   rise_ie;
      logic   out_en;
      logic   gate_en;
      logic   single;
      tmode_e mode;
   } tctrl_t;

   localparam int CTRL_W = $bits(tctrl_t);

   localparam int A_CTRL = 0;
   localparam int A_PSC  = 1;
   localparam int A_RISE = 2;
   localparam int A_FALL = 3;
   localparam int A_RUN  = 4;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= din;
         end
         assign dout = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= {stage_q[STAGES-2:0], din};
         end
         assign dout = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PSC_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             enable,
   input  logic [PSC_W-1:0] exp_sel,
   output logic             tick
);

   localparam int DIV_W = (1 << PSC_W) - 1;

   logic [DIV_W-1:0] phase_q;
   logic [DIV_W-1:0] mask;

   // low exp_sel bits set: tick whenever those bits of the phase are all ones
   assign mask = ~({DIV_W{1'b1}} << exp_sel);
   assign tick = enable && ((phase_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase_q <= '0;
      else if (clear)  phase_q <= '0;
      else if (enable) phase_q <= phase_q + DIV_W'(1);
   end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import modal_timer_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  tmode_e           mode,
   input  logic             single,
   input  logic             gate_en,
   input  logic             rise_ie,
   input  logic             fall_ie,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             tick,
   input  logic             gate_lvl,
   input  logic             gate_re,
   input  logic             cap_re,
   input  logic             cap_fe,
   input  logic             rise_wr,
   input  logic             fall_wr,
   input  logic [CNT_W-1:0] wr_val,
   output logic             run_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] rise_q,
   output logic [CNT_W-1:0] fall_q,
   output logic             pwm_q,
   output logic             irq_rise,
   output logic             irq_fall
);

   logic             is_cap, is_cnt, frozen, step;
   logic             rise_hit, fall_hit, cap_r, cap_f;
   logic [CNT_W-1:0] cnt_inc;

   assign is_cap  = (mode == MODE_CAPTURE);
   assign is_cnt  = (mode == MODE_COUNT);
   assign frozen  = gate_en && gate_lvl && !is_cnt;
   assign step    = run_q && (is_cnt ? gate_re : (tick && !frozen));
   assign cnt_inc = cnt_q + CNT_W'(1);

   // compare matches look at the value the counter is about to take
   assign rise_hit = step && !is_cap && (cnt_inc == rise_q);
   assign fall_hit = step && !is_cap && (cnt_inc == fall_q);
   assign cap_r    = run_q && is_cap && cap_re;
   assign cap_f    = run_q && is_cap && cap_fe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         pwm_q <= 1'b0;
      end else if (start_req) begin
         run_q <= 1'b1;
         cnt_q <= '0;
         pwm_q <= 1'b0;
      end else begin
         if (stop_req) run_q <= 1'b0;
         if (fall_hit) begin
            if (single) begin
               cnt_q <= fall_q;
               run_q <= 1'b0;
            end else begin
               cnt_q <= '0;
            end
         end else if (step) begin
            cnt_q <= cnt_inc;
         end
         if (mode == MODE_PWM) begin
            if (fall_hit)      pwm_q <= 1'b0;
            else if (rise_hit) pwm_q <= 1'b1;
         end else begin
            pwm_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q <= '0;
         fall_q <= '0;
      end else begin
         if (rise_wr)    rise_q <= wr_val;
         else if (cap_r) rise_q <= cnt_q;
         if (fall_wr)    fall_q <= wr_val;
         else if (cap_f) fall_q <= cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_rise <= 1'b0;
         irq_fall <= 1'b0;
      end else begin
         irq_rise <= rise_ie && (rise_hit || cap_r);
         irq_fall <= fall_ie && (fall_hit || cap_f);
      end
   end

endmodule

// File: rtl/modal_timer.sv
module modal_timer
   import modal_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              gate_in,
   input  logic              cap_in,
   output logic              pwm_out,
   output logic              pwm_oe,
   output logic              irq_rise,
   output logic              irq_fall,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  rise_o,
   output logic [CNT_W-1:0]  fall_o
);

   generate
      if (CNT_W < CTRL_W + 1) begin : g_bad_cnt
         $error("modal_timer: CNT_W too narrow for the control word");
      end
      if (PSC_W < 1 || PSC_W > 5) begin : g_bad_psc
         $error("modal_timer: PSC_W must lie in 1..5");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("modal_timer: SYNC_STAGES must be at least 1");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("modal_timer: ADDR_W must be at least 3");
      end
   endgenerate

   tctrl_t           ctrl_q;
   logic [PSC_W-1:0] psc_q;
   logic             sel_ctrl, sel_psc, sel_rise, sel_fall, sel_run;
   logic             start_req, stop_req;
   logic             tick, run_s, pwm_s;
   logic [1:0]       pin_lvl, pin_prev;
   logic             gate_lvl, gate_re, cap_re, cap_fe;
   logic [CNT_W-1:0] cnt_s, rise_s, fall_s;

   assign sel_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign sel_psc   = wr_en && (wr_addr == ADDR_W'(A_PSC));
   assign sel_rise  = wr_en && (wr_addr == ADDR_W'(A_RISE));
   assign sel_fall  = wr_en && (wr_addr == ADDR_W'(A_FALL));
   assign sel_run   = wr_en && (wr_addr == ADDR_W'(A_RUN));
   assign start_req = sel_run && wr_data[0];
   assign stop_req  = sel_run && !wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         psc_q  <= '0;
      end else begin
         if (sel_ctrl) ctrl_q <= tctrl_t'(wr_data[CTRL_W-1:0]);
         if (sel_psc)  psc_q  <= wr_data[PSC_W-1:0];
      end
   end

   // bit 0: clock/gate pin, bit 1: capture pin
   tmr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({cap_in, gate_in}),
      .dout  (pin_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= '0;
      else        pin_prev <= pin_lvl;
   end

   assign gate_lvl = pin_lvl[0];
   assign gate_re  = pin_lvl[0] && !pin_prev[0];
   assign cap_re   = pin_lvl[1] && !pin_prev[1];
   assign cap_fe   = !pin_lvl[1] && pin_prev[1];

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_req),
      .enable  (run_s),
      .exp_sel (psc_q),
      .tick    (tick)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (ctrl_q.mode),
      .single    (ctrl_q.single),
      .gate_en   (ctrl_q.gate_en),
      .rise_ie   (ctrl_q.rise_ie),
      .fall_ie   (ctrl_q.fall_ie),
      .start_req (start_req),
      .stop_req  (stop_req),
      .tick      (tick),
      .gate_lvl  (gate_lvl),
      .gate_re   (gate_re),
      .cap_re    (cap_re),
      .cap_fe    (cap_fe),
      .rise_wr   (sel_rise),
      .fall_wr   (sel_fall),
      .wr_val    (wr_data),
      .run_q     (run_s),
      .cnt_q     (cnt_s),
      .rise_q    (rise_s),
      .fall_q    (fall_s),
      .pwm_q     (pwm_s),
      .irq_rise  (irq_rise),
      .irq_fall  (irq_fall)
   );

   assign pwm_oe  = ctrl_q.out_en;
   assign pwm_out = pwm_s && ctrl_q.out_en;
   assign count_o = cnt_s;
   assign rise_o  = rise_s;
   assign fall_o  = fall_s;

endmodule

// File: rtl/modal_timer_chk.sv
module modal_timer_chk
   import modal_timer_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input tmode_e           mode,
   input logic             gate_en,
   input logic             rise_ie,
   input logic             fall_ie,
   input logic             start_req,
   input logic             stop_req,
   input logic             run_q,
   input logic             gate_lvl,
   input logic             gate_re,
   input logic             pwm_q,
   input logic             irq_rise,
   input logic             irq_fall,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] rise_q,
   input logic [CNT_W-1:0] fall_q
);

   assert_irq_rise_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rise |-> $past(rise_ie));

   assert_irq_fall_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fall |-> $past(fall_ie));

   assert_single_holds_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run_q) && !$past(stop_req)) |-> (cnt_q == fall_q));

   assert_gate_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && gate_en && gate_lvl && mode != MODE_COUNT && !start_req) |=> $stable(cnt_q));

   assert_count_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && mode == MODE_COUNT && !gate_re && !start_req) |=> $stable(cnt_q));

   assert_pwm_rises_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_q) |-> (cnt_q == rise_q));

   assert_stop_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> !run_q);

endmodule

bind modal_timer modal_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (ctrl_q.mode),
   .gate_en   (ctrl_q.gate_en),
   .rise_ie   (ctrl_q.rise_ie),
   .fall_ie   (ctrl_q.fall_ie),
   .start_req (start_req),
   .stop_req  (stop_req),
   .run_q     (run_s),
   .gate_lvl  (gate_lvl),
   .gate_re   (gate_re),
   .pwm_q     (pwm_s),
   .irq_rise  (irq_rise),
   .irq_fall  (irq_fall),
   .cnt_q     (cnt_s),
   .rise_q    (rise_s),
   .fall_q    (fall_s)
);

// File: tb/tb_modal_timer.sv
module tb_modal_timer;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          gate_in = 1'b0;
   logic          cap_in = 1'b0;
   logic          pwm_out, pwm_oe, irq_rise, irq_fall;
   logic [CW-1:0] count_o, rise_o, fall_o;

   modal_timer dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .gate_in  (gate_in),
      .cap_in   (cap_in),
      .pwm_out  (pwm_out),
      .pwm_oe   (pwm_oe),
      .irq_rise (irq_rise),
      .irq_fall (irq_fall),
      .count_o  (count_o),
      .rise_o   (rise_o),
      .fall_o   (fall_o)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   int rise_hi = 0;
   int fall_hi = 0;
   int last_cyc = 0;
   bit last_ok = 1'b0;
   int exp_q[$];

   task automatic chk(string req, string what, longint act, longint expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // monitor: counts interrupt-high cycles and pops expected Fall intervals
   task automatic monitor();
      forever begin
         @(negedge clk);
         if (irq_rise === 1'b1) rise_hi++;
         if (irq_fall === 1'b1) begin
            fall_hi++;
            if (last_ok && exp_q.size() > 0)
               chk("R3", "fall interrupt interval", longint'(cyc - last_cyc), longint'(exp_q.pop_front()));
            last_cyc = cyc;
            last_ok  = 1'b1;
         end
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 3'(a);
      wr_data = CW'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_gaps(int n, int gap);
      for (int i = 0; i < n; i++) exp_q.push_back(gap);
   endtask

   task automatic high_cycles(int window, output int hi);
      hi = 0;
      for (int i = 0; i < window; i++) begin
         @(negedge clk);
         if (pwm_out === 1'b1) hi++;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int c1;
      int hi;
      fork
         monitor();
      join_none

      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1", "count", count_o, 0);
      chk("R1", "rise reg", rise_o, 0);
      chk("R1", "fall reg", fall_o, 0);
      chk("R1", "irq_rise", irq_rise, 0);
      chk("R1", "irq_fall", irq_fall, 0);
      chk("R1", "pwm_out", pwm_out, 0);
      chk("R1", "pwm_oe", pwm_oe, 0);

      // R2 prescaled stepping and start clearing
      wr(1, 2);
      wr(3, 1000);
      wr(0, 0);
      wr(4, 1);
      idle(40);
      chk("R2", "count after 40 clocks at e=2", count_o, 10);
      wr(4, 1);
      chk("R2", "count cleared by restart", count_o, 0);
      wr(1, 0);
      wr(4, 1);
      idle(13);
      chk("R2", "count after 13 clocks at e=0", count_o, 13);

      // R3 repeating timer, scoreboard of interrupt gaps
      wr(4, 0);
      wr(1, 1);
      wr(3, 6);
      wr(0, 1 << 6);
      last_ok = 1'b0;
      fall_hi = 0;
      push_gaps(3, 12);
      wr(4, 1);
      idle(55);
      chk("R3", "pending gaps at e=1", exp_q.size(), 0);
      chk("R3", "pulses at e=1", fall_hi, 4);
      wr(4, 0);
      wr(1, 0);
      wr(3, 9);
      last_ok = 1'b0;
      fall_hi = 0;
      push_gaps(3, 9);
      wr(4, 1);
      idle(40);
      chk("R3", "pending gaps at e=0", exp_q.size(), 0);
      chk("R3", "pulses at e=0", fall_hi, 4);

      // R4 single-shot
      wr(4, 0);
      wr(3, 5);
      wr(0, (1 << 6) | (1 << 2));
      fall_hi = 0;
      wr(4, 1);
      idle(30);
      chk("R4", "single-shot fall pulses", fall_hi, 1);
      chk("R4", "single-shot holds at Fall", count_o, 5);
      idle(10);
      chk("R4", "still holding", count_o, 5);

      // R10 interrupt masked by its enable bit
      wr(0, 1 << 2);
      fall_hi = 0;
      wr(4, 1);
      idle(30);
      chk("R10", "masked fall pulses", fall_hi, 0);
      chk("R10", "masked run still ends at Fall", count_o, 5);

      // R11 stop
      wr(0, 0);
      wr(3, 1000);
      wr(4, 1);
      idle(10);
      wr(4, 0);
      chk("R11", "count at stop", count_o, 12);
      idle(20);
      chk("R11", "count held after stop", count_o, 12);

      // R5 gate enabled freezes
      wr(0, 1 << 3);
      wr(4, 1);
      idle(5);
      gate_in = 1'b1;
      idle(10);
      c1 = int'(count_o);
      chk("R5", "count when gate closes", c1, 7);
      idle(20);
      chk("R5", "count frozen while gate high", count_o, c1);
      gate_in = 1'b0;
      idle(20);
      chk("R5", "count resumes after gate low", count_o, 25);
      // R5 gate disabled: pin ignored
      wr(0, 0);
      gate_in = 1'b1;
      wr(4, 1);
      idle(20);
      chk("R5", "gate pin ignored when disabled", count_o, 20);
      gate_in = 1'b0;
      idle(5);

      // R6 edge-count mode with slow prescale
      wr(4, 0);
      wr(1, 3);
      wr(0, 3);
      wr(4, 1);
      for (int i = 0; i < 7; i++) begin
         gate_in = 1'b1;
         idle(3);
         gate_in = 1'b0;
         idle(3);
      end
      idle(5);
      chk("R6", "seven edges", count_o, 7);
      for (int i = 0; i < 5; i++) begin
         gate_in = 1'b1;
         idle(4);
         gate_in = 1'b0;
         idle(2);
      end
      idle(5);
      chk("R6", "twelve edges", count_o, 12);

      // R7 PWM phase and duty
      wr(4, 0);
      wr(1, 0);
      wr(2, 3);
      wr(3, 8);
      wr(0, 1 | (1 << 4));
      wr(4, 1);
      chk("R7", "pwm low at start", pwm_out, 0);
      idle(2);
      chk("R7", "pwm low before Rise", pwm_out, 0);
      idle(1);
      chk("R7", "pwm high at Rise", pwm_out, 1);
      idle(5);
      chk("R7", "pwm low at Fall", pwm_out, 0);
      high_cycles(80, hi);
      chk("R7", "high cycles in 10 periods e=0", hi, 50);
      chk("R8", "output enable pin set", pwm_oe, 1);
      wr(4, 0);
      wr(1, 1);
      wr(2, 2);
      wr(3, 6);
      wr(4, 1);
      idle(5);
      high_cycles(120, hi);
      chk("R7", "high cycles in 10 periods e=1", hi, 80);
      // R8 output disabled
      wr(0, 1);
      chk("R8", "output enable pin clear", pwm_oe, 0);
      high_cycles(60, hi);
      chk("R8", "pwm held low when disabled", hi, 0);

      // R9 capture of high and low time
      wr(4, 0);
      wr(1, 0);
      wr(0, 2 | (1 << 5) | (1 << 6));
      rise_hi = 0;
      fall_hi = 0;
      wr(4, 1);
      idle(5);
      cap_in = 1'b1;
      idle(7);
      cap_in = 1'b0;
      idle(6);
      chk("R9", "high time", longint'(CW'(fall_o - rise_o)), 7);
      idle(5);
      cap_in = 1'b1;
      idle(6);
      chk("R9", "low time", longint'(CW'(rise_o - fall_o)), 11);
      chk("R9", "rise capture interrupts (R10 one cycle each)", rise_hi, 2);
      chk("R9", "fall capture interrupts (R10 one cycle each)", fall_hi, 1);
      cap_in = 1'b0;
      idle(5);

      summary();
      $finish;
   end

endmodule